// File: doc/BRIEF.md
# Byte-Wide Flash Command Sequencer

This block is a device-side behavioural model of a byte-wide flash memory built from uniform 128-byte sectors. A host talks to it over a simple synchronous bus: an active-low chip select, an active-low write strobe, an active-low output enable, an address and an 8-bit write data bus. A write takes effect only as the last step of a fixed unlock sequence. The block decodes those sequences into byte programming, sector erase or full-array erase. It then runs the internal operation for a fixed number of clock cycles, set by a parameter, so that a simulation stays short.

While an internal operation is in progress, every write cycle is dropped. A read then returns two end-of-write status bits in place of array data: a complemented data bit and a bit that flips on each read. When the operation has finished, reads return the array contents again. The host bus is a plain strobe bus, not a stream. Every write cycle is taken in the clock cycle in which it appears, and the block never holds the host back. The host detects completion by polling the status bits.

Top module: `flash_cmd_top`

## Requirements
- R1: After reset the block is idle, every array byte reads FFh, and `rdata_oe` is low while `ce_n` is high.
- R2: `rdata_oe` is high only when `ce_n` and `oe_n` are low and `we_n` is high. When idle, `rdata` is then the array byte at `addr` modulo DEPTH, available in the same cycle.
- R3: Writing 555h/AAh, then 2AAh/55h, then 555h/A0h, then a fourth cycle carrying address and data programs that byte. The new value is the old byte ANDed with the data, so programming can only clear bits.
- R4: Writing 555h/AAh, 2AAh/55h, 555h/80h, 555h/AAh, 2AAh/55h and then data 20h at any address sets all 128 bytes of the sector holding that address to FFh. Bytes in other sectors are left unchanged.
- R5: The same five set-up cycles followed by data 10h at address 555h set the whole array to FFh. Data 10h at any other address starts nothing.
- R6: A write cycle that does not match the expected address/data pair of the sequence returns the decoder to idle. A later cycle is then not taken as a sequence step.
- R7: The internal operation starts at the clock edge that captures the final write. It stays busy for PROG_CYC cycles (program), SECT_CYC cycles (sector erase) or CHIP_CYC cycles (chip erase). The next read returns array data.
- R8: Write cycles that arrive while an operation is busy are ignored and leave the array unchanged.
- R9: A read while busy returns bit 7 as the complement of the programmed data bit 7, or 0 during an erase. Bits 5 to 0 read as 0.
- R10: While busy, bit 6 of the read data flips after each read cycle. It does not flip on cycles that are not reads.
- R11: Read cycles placed between the steps of a command sequence do not disturb the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write strobe; a write cycle is a cycle with ce_n and we_n both low |
| oe_n | input | 1 | Active-low output enable |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data / command byte |
| rdata | output | 8 | Read data, or status while busy |
| rdata_oe | output | 1 | High when the model drives the data bus; low stands for high impedance |

## Verification
The assertions check a number of rules on every clock cycle:
- An operation is launched only while the block is idle.
- The busy flag rises only directly after a launch.
- Busy never drops before the array-fill walk has finished.
- An idle read of a fixed address stays stable while nothing is written.

The bench scenarios show the effects that only appear at the ports:
- The exact cycle at which data returns.
- AND-style reprogramming.
- Sector bounds of an erase.
- Aborted and interleaved sequences.
- Commands dropped while busy.
- Toggle behaviour when read cycles and idle cycles are mixed.

// File: rtl/flash_pkg.sv
`timescale 1ns/1ps
package flash_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_U1, SQ_U2, SQ_PGM, SQ_E1, SQ_E2, SQ_E3
  } seq_t;

  typedef enum logic [1:0] {
    OP_NONE, OP_PROG, OP_SECT, OP_CHIP
  } op_t;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_ERASE  = 8'h80;
  localparam logic [7:0] CMD_SECT   = 8'h20;
  localparam logic [7:0] CMD_CHIP   = 8'h10;
endpackage

// File: rtl/flash_seq_decoder.sv
`timescale 1ns/1ps
module flash_seq_decoder
  import flash_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] UNL_A = 'h555,
  parameter logic [ADDR_W-1:0] UNL_B = 'h2AA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cyc_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              busy_i,
  output logic              start_o,
  output op_t               op_o
);
  seq_t st, st_nxt;

  logic hit_a_first, hit_b_second;
  assign hit_a_first  = (addr_i == UNL_A) && (data_i == KEY_FIRST);
  assign hit_b_second = (addr_i == UNL_B) && (data_i == KEY_SECOND);

  always_comb begin
    st_nxt  = st;
    start_o = 1'b0;
    op_o    = OP_NONE;
    if (wr_cyc_i && !busy_i) begin
      unique case (st)
        SQ_IDLE: st_nxt = hit_a_first ? SQ_U1 : SQ_IDLE;
        SQ_U1:   st_nxt = hit_b_second ? SQ_U2 : SQ_IDLE;
        SQ_U2: begin
          if (addr_i == UNL_A && data_i == CMD_PROG)       st_nxt = SQ_PGM;
          else if (addr_i == UNL_A && data_i == CMD_ERASE) st_nxt = SQ_E1;
          else                                             st_nxt = SQ_IDLE;
        end
        SQ_PGM: begin
          start_o = 1'b1;
          op_o    = OP_PROG;
          st_nxt  = SQ_IDLE;
        end
        SQ_E1: st_nxt = hit_a_first ? SQ_E2 : SQ_IDLE;
        SQ_E2: st_nxt = hit_b_second ? SQ_E3 : SQ_IDLE;
        SQ_E3: begin
          st_nxt = SQ_IDLE;
          if (data_i == CMD_SECT) begin
            start_o = 1'b1;
            op_o    = OP_SECT;
          end else if (data_i == CMD_CHIP && addr_i == UNL_A) begin
            start_o = 1'b1;
            op_o    = OP_CHIP;
          end
        end
        default: st_nxt = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= SQ_IDLE;
    else        st <= st_nxt;
  end

  // R8: a launch is never issued while the engine reports busy
  p_launch_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> !busy_i);
endmodule

// File: rtl/flash_op_engine.sv
`timescale 1ns/1ps
module flash_op_engine
  import flash_pkg::*;
#(
  parameter int DEPTH      = 512,
  parameter int SECT_BYTES = 128,
  parameter int PROG_CYC   = 8,
  parameter int SECT_CYC   = 160,
  parameter int CHIP_CYC   = 600,
  localparam int AW        = $clog2(DEPTH),
  localparam int SECT_AW   = $clog2(SECT_BYTES),
  localparam int CW        = $clog2(CHIP_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  op_t           op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  input  logic          rd_cyc_i,
  input  logic [7:0]    old_byte_i,
  output logic          busy_o,
  output logic [7:0]    status_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_waddr_o,
  output logic [7:0]    mem_wdata_o
);
  logic [CW-1:0] cnt;
  logic [AW:0]   left;
  logic [AW-1:0] ptr;
  op_t           op_q;
  logic [7:0]    data_q;
  logic          tog;

  logic [CW-1:0] dur_load;
  logic [AW:0]   walk_len;
  logic [AW-1:0] walk_base;

  always_comb begin
    unique case (op_i)
      OP_PROG: begin
        dur_load  = CW'(PROG_CYC - 1);
        walk_len  = (AW+1)'(1);
        walk_base = addr_i;
      end
      OP_SECT: begin
        dur_load  = CW'(SECT_CYC - 1);
        walk_len  = (AW+1)'(SECT_BYTES);
        walk_base = {addr_i[AW-1:SECT_AW], {SECT_AW{1'b0}}};
      end
      default: begin
        dur_load  = CW'(CHIP_CYC - 1);
        walk_len  = (AW+1)'(DEPTH);
        walk_base = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      cnt    <= '0;
      left   <= '0;
      ptr    <= '0;
      op_q   <= OP_NONE;
      data_q <= '0;
      tog    <= 1'b0;
    end else begin
      if (start_i) begin
        busy_o <= 1'b1;
        cnt    <= dur_load;
        left   <= walk_len;
        ptr    <= walk_base;
        op_q   <= op_i;
        data_q <= data_i;
      end else if (busy_o) begin
        if (cnt == '0) busy_o <= 1'b0;
        else           cnt    <= cnt - 1'b1;
        if (left != '0) begin
          left <= left - 1'b1;
          ptr  <= ptr + 1'b1;
        end
      end
      if (rd_cyc_i && busy_o) tog <= ~tog;
    end
  end

  assign mem_we_o    = busy_o && (left != '0);
  assign mem_waddr_o = ptr;
  assign mem_wdata_o = (op_q == OP_PROG) ? (old_byte_i & data_q) : 8'hFF;
  assign status_o    = {(op_q == OP_PROG) ? ~data_q[7] : 1'b0, tog, 6'b0};

  // R7: busy never ends while array bytes of the operation remain to be written
  p_walk_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (left == '0));
  // R7: busy rises only in the cycle after a launch
  p_busy_after_launch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));
endmodule

// File: rtl/flash_store.sv
`timescale 1ns/1ps
module flash_store #(
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o,
  input  logic [AW-1:0] paddr_i,
  output logic [7:0]    pdata_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];
  assign pdata_o = mem[paddr_i];
endmodule

// File: rtl/flash_cmd_top.sv
`timescale 1ns/1ps
module flash_cmd_top
  import flash_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DEPTH      = 512,
  parameter int SECT_BYTES = 128,
  parameter int PROG_CYC   = 8,
  parameter int SECT_CYC   = 160,
  parameter int CHIP_CYC   = 600,
  parameter logic [ADDR_W-1:0] UNL_A = 'h555,
  parameter logic [ADDR_W-1:0] UNL_B = 'h2AA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              rdata_oe
);
  localparam int AW = $clog2(DEPTH);

  logic          wr_cyc, rd_cyc;
  logic          start, busy;
  op_t           op;
  logic [7:0]    status, arr_rd, arr_old, mem_wdata;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;

  assign wr_cyc = !ce_n && !we_n;
  assign rd_cyc = !ce_n && !oe_n && we_n;

  flash_seq_decoder #(.ADDR_W(ADDR_W), .UNL_A(UNL_A), .UNL_B(UNL_B)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_cyc_i(wr_cyc), .addr_i(addr),
    .data_i(wdata), .busy_i(busy), .start_o(start), .op_o(op)
  );

  flash_op_engine #(
    .DEPTH(DEPTH), .SECT_BYTES(SECT_BYTES), .PROG_CYC(PROG_CYC),
    .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op),
    .addr_i(addr[AW-1:0]), .data_i(wdata), .rd_cyc_i(rd_cyc),
    .old_byte_i(arr_old), .busy_o(busy), .status_o(status),
    .mem_we_o(mem_we), .mem_waddr_o(mem_waddr), .mem_wdata_o(mem_wdata)
  );

  flash_store #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n), .we_i(mem_we), .waddr_i(mem_waddr),
    .wdata_i(mem_wdata), .raddr_i(addr[AW-1:0]), .rdata_o(arr_rd),
    .paddr_i(mem_waddr), .pdata_o(arr_old)
  );

  assign rdata    = busy ? status : arr_rd;
  assign rdata_oe = rd_cyc;

  // R2: an idle read of an unchanged address with no array write stays stable
  p_read_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && !$past(mem_we) && rdata_oe && $past(rdata_oe)
     && addr == $past(addr)) |-> rdata == $past(rdata));
endmodule

// File: tb/sim_flash_cmd_top.sv
`timescale 1ns/1ps
module sim_flash_cmd_top;
  localparam int PROG_CYC = 8;
  localparam int SECT_CYC = 160;
  localparam int CHIP_CYC = 600;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [11:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rdata_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flash_cmd_top #(.PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  // kind: 0 write, 1 read and compare, 2 idle for <data> cycles
  localparam int NV = 17;
  localparam logic [29:0] VEC [NV] = '{
    {2'd1, 12'h010, 8'h00, 8'hFF},  // R1 erased after reset
    {2'd0, 12'h555, 8'hAA, 8'h00},
    {2'd0, 12'h2AA, 8'h55, 8'h00},
    {2'd0, 12'h555, 8'hA0, 8'h00},
    {2'd0, 12'h010, 8'h3C, 8'h00},  // R3 program
    {2'd1, 12'h010, 8'h00, 8'h80},  // R9/R10 busy status
    {2'd1, 12'h010, 8'h00, 8'hC0},
    {2'd1, 12'h010, 8'h00, 8'h80},
    {2'd2, 12'h000, 8'd8,  8'h00},
    {2'd1, 12'h010, 8'h00, 8'h3C},  // R3 result
    {2'd0, 12'h555, 8'hAA, 8'h00},
    {2'd0, 12'h2AA, 8'h55, 8'h00},
    {2'd0, 12'h555, 8'hA0, 8'h00},
    {2'd0, 12'h010, 8'hF0, 8'h00},
    {2'd2, 12'h000, 8'd8,  8'h00},
    {2'd1, 12'h010, 8'h00, 8'h30},  // R3 AND with old byte
    {2'd1, 12'h011, 8'h00, 8'hFF}   // R3 neighbour untouched
  };

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [7:0] d);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd(logic [11:0] a, output logic [7:0] v);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
    #1 v = rdata;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock_prog(logic [11:0] a, logic [7:0] d);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0); wr(a, d);
  endtask

  task automatic erase_setup();
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, b1;
    idle(3);
    #1 checks++;
    if (rdata_oe !== 1'b0) begin errors++; $display("FAIL R1 rdata_oe %b expected 0", rdata_oe); end
    @(negedge clk);
    rst_n = 1'b1;
    idle(1);

    for (int i = 0; i < NV; i++) begin
      unique case (VEC[i][29:28])
        2'd0: wr(VEC[i][27:16], VEC[i][15:8]);
        2'd1: begin rd(VEC[i][27:16], v); check($sformatf("R3/R9/R10 vec %0d", i), v, VEC[i][7:0]); end
        default: idle(int'(VEC[i][15:8]));
      endcase
    end

    // R7 exact end of busy
    unlock_prog(12'h020, 8'h7F);
    idle(PROG_CYC - 1);
    rd(12'h020, v); check("R7 last busy cycle", v & 8'hBF, 8'h80);
    rd(12'h020, v); check("R7 first data cycle", v, 8'h7F);

    // R9 / R10 toggle on reads only
    unlock_prog(12'h021, 8'h80);
    rd(12'h021, v); check("R9 program dq7", v & 8'hBF, 8'h00);
    b1 = v & 8'h40;
    idle(2);
    rd(12'h021, v); check("R10 flip after one read", v & 8'h40, b1 ^ 8'h40);
    rd(12'h021, v); check("R10 flip back", v & 8'h40, b1);
    idle(PROG_CYC);
    rd(12'h021, v); check("R3 program 80", v, 8'h80);

    // R6 aborted sequences
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h77); wr(12'h030, 8'h00);
    idle(PROG_CYC);
    rd(12'h030, v); check("R6 bad command byte", v, 8'hFF);
    wr(12'h555, 8'hAA); wr(12'h555, 8'h55); wr(12'h555, 8'hA0); wr(12'h031, 8'h00);
    idle(PROG_CYC);
    rd(12'h031, v); check("R6 bad second address", v, 8'hFF);

    // R11 reads interleaved with a sequence
    wr(12'h555, 8'hAA);
    rd(12'h040, v); check("R11 idle read mid sequence", v, 8'hFF);
    wr(12'h2AA, 8'h55);
    rd(12'h040, v);
    wr(12'h555, 8'hA0); wr(12'h040, 8'h5A);
    idle(PROG_CYC);
    rd(12'h040, v); check("R11 program after interleaved reads", v, 8'h5A);

    // prefill a byte in sector 1
    unlock_prog(12'h080, 8'h12);
    idle(PROG_CYC);

    // R4 sector erase, R8 commands ignored while busy
    erase_setup(); wr(12'h005, 8'h20);
    rd(12'h005, v); check("R9 erase dq7", v & 8'hBF, 8'h00);
    unlock_prog(12'h100, 8'h00);
    idle(SECT_CYC);
    rd(12'h010, v); check("R4 sector byte 10", v, 8'hFF);
    rd(12'h07F, v); check("R4 sector last byte", v, 8'hFF);
    rd(12'h040, v); check("R4 sector byte 40", v, 8'hFF);
    rd(12'h080, v); check("R4 next sector kept", v, 8'h12);
    rd(12'h100, v); check("R8 write while busy ignored", v, 8'hFF);

    // R5 chip erase, wrong address first
    erase_setup(); wr(12'h123, 8'h10);
    rd(12'h080, v); check("R5 chip command at wrong address", v, 8'h12);
    erase_setup(); wr(12'h555, 8'h10);
    rd(12'h080, v); check("R5/R9 chip erase busy dq7", v & 8'hBF, 8'h00);
    idle(CHIP_CYC);
    rd(12'h080, v); check("R5 chip erase 080", v, 8'hFF);
    rd(12'h1FF, v); check("R5 chip erase 1FF", v, 8'hFF);

    // R2 output enable gating
    ce_n = 1'b1; oe_n = 1'b0; #1
    check("R2 oe with ce high", {7'b0, rdata_oe}, 8'h00);
    ce_n = 1'b0; oe_n = 1'b1; #1
    check("R2 oe with oe_n high", {7'b0, rdata_oe}, 8'h00);
    oe_n = 1'b0; #1
    check("R2 oe with both low", {7'b0, rdata_oe}, 8'h01);
    check("R2 idle read data", rdata, 8'hFF);
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule